// File: doc/BRIEF.md
# Speculative Load-Store Ordering Queue

This block keeps the memory operations that are in flight, loads in one ring and stores in another, each in program order. A load may execute before older stores whose target addresses are not yet known. Such a load is speculative. When a store later reports its address, the block compares that address with every younger load that has already executed. If any of them touches the same bytes, the block requests a squash and names the oldest such load. The pipeline around the block replays that load and everything after it. The block does not access the cache and does not perform recovery.

Each 8-byte word is addressed by a word index plus an 8-bit byte mask. Two accesses overlap when they have the same word index and their masks share at least one set bit. At allocation, every load records how many stores had been allocated up to that point, and this count decides which stores are older than the load. A one-bit wait table remembers load PCs that caused a squash. When such a PC appears again, the block holds the load back while any store older than it still has an unknown address. A query port reports whether a given load has become safe.

Top module: `lsq_disamb_top`

## Requirements
- R1: After reset both rings are empty. `alloc_ready` is 1, `alloc_idx` is 0, `squash_valid` is 0 and `qry_safe` is 0.
- R2: Allocation fills the ring picked by `alloc_store` (1 = store) in order. `alloc_idx` shows the slot the operation will take. Slots count up from 0 and wrap after the last slot (40 loads, 24 stores by default). `alloc_ready` is 0 when the picked ring is full, and no entry is written in that case.
- R3: `retire_ld` and `retire_st` each free the oldest entry of their ring. Retiring from an empty ring has no effect.
- R4: A load whose PC has a clear wait bit gets `ld_iss_ok`=1 and executes even if older stores have unknown addresses.
- R5: One cycle after a store address resolves, `squash_valid` is 1 if an executed load younger than that store overlaps it. `squash_idx` then names the oldest such load, counted from the oldest load in the ring.
- R6: A resolving store whose word index differs from every executed load, or whose mask is disjoint from theirs, causes no squash.
- R7: A load allocated before a store is never squashed by that store.
- R8: A squash sets the wait bit of the offending load's PC. The wait index is the XOR-fold of all PC bits in 6-bit groups: bit b goes to index bit b mod 6. A load whose wait bit is set gets `ld_iss_ok`=0 while an older store has an unknown address. It gets `ld_iss_ok`=1 once all older stores are known.
- R9: `qry_safe` is 1 for a load only if it has executed and every older store still in the ring has a known address that does not overlap the load.
- R10: A load that issues in the same cycle as an older overlapping store resolves is squashed.
- R11: A squash clears the executed state of the offending load and of every load younger than it. Their `qry_safe` reads 0 until they issue again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate one operation this cycle |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_pc | input | PC_W | PC of the allocated load |
| alloc_ready | output | 1 | Picked ring has room |
| alloc_idx | output | IDX_W | Slot the operation takes |
| st_res_valid | input | 1 | Store address resolves |
| st_res_idx | input | SQ_W | Store slot |
| st_res_word | input | WORD_W | Store 8-byte word index |
| st_res_mask | input | 8 | Store byte mask |
| ld_iss_valid | input | 1 | Load requests to execute |
| ld_iss_idx | input | LQ_W | Load slot |
| ld_iss_word | input | WORD_W | Load 8-byte word index |
| ld_iss_mask | input | 8 | Load byte mask |
| ld_iss_ok | output | 1 | Load is allowed to execute |
| squash_valid | output | 1 | Squash request |
| squash_idx | output | LQ_W | Oldest offending load slot |
| qry_idx | input | LQ_W | Load slot to query |
| qry_safe | output | 1 | Queried load is safe |
| retire_ld | input | 1 | Free the oldest load |
| retire_st | input | 1 | Free the oldest store |

## Verification
The assertions assume the surroundings only resolve or issue slots that hold a live entry. They also assume each store address is resolved at most once while it occupies its slot. The random stimulus keeps to these rules by choosing targets from a bench-side mirror of the live entries: only unresolved stores are resolved and only loads that have not executed are issued. Word indices are kept to a small range so that overlaps, squashes and wait-table hits occur often.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int SEQ_W = 8;
  typedef logic [SEQ_W-1:0] seq_t;
  typedef logic [7:0] bmask_t;

  // store tag st is older than a load carrying mark (wrap-safe while fewer than 2**(SEQ_W-1) stores live)
  function automatic logic seq_before(seq_t st, seq_t mark);
    seq_t diff;
    diff = mark - st;
    return (diff != '0) && !diff[SEQ_W-1];
  endfunction

  function automatic logic masks_touch(bmask_t a, bmask_t b);
    return (a & b) != '0;
  endfunction
endpackage

// File: rtl/lsq_ring_ctl.sv
module lsq_ring_ctl #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] head_d, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    head_d = head;
    tail_d = tail;
    cnt_d  = cnt_q;
    if (pop) begin
      head_d = (head == PW'(DEPTH - 1)) ? '0 : head + 1'b1;
    end
    if (push) begin
      tail_d = (tail == PW'(DEPTH - 1)) ? '0 : tail + 1'b1;
    end
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      cnt_q <= '0;
    end else if (push || pop) begin
      head  <= head_d;
      tail  <= tail_d;
      cnt_q <= cnt_d;
    end
  end

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R3
  AST_EMPTY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) empty |-> (head == tail)); // R3
endmodule

// File: rtl/lsq_wait_pred.sv
module lsq_wait_pred #(
  parameter int PC_W = 32,
  parameter int IDX_W = 6,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_wait,
  input  logic            set_en,
  input  logic [PC_W-1:0] set_pc
);
  logic [ENTRIES-1:0] tbl_q, tbl_d;
  logic [IDX_W-1:0]   rd_ix, set_ix;

  function automatic logic [IDX_W-1:0] fold(logic [PC_W-1:0] pc);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int b = 0; b < PC_W; b++) h[b % IDX_W] = h[b % IDX_W] ^ pc[b];
    return h;
  endfunction

  always_comb begin
    rd_ix  = fold(rd_pc);
    set_ix = fold(set_pc);
    tbl_d  = tbl_q;
    if (set_en) tbl_d[set_ix] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_q <= '0;
    else if (set_en) tbl_q <= tbl_d;
  end

  assign rd_wait = tbl_q[rd_ix];

  AST_PRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_en) |-> tbl_q[$past(set_ix)]); // R8
endmodule

// File: rtl/lsq_disamb_top.sv
module lsq_disamb_top #(
  parameter int LQ_DEPTH = 40,
  parameter int SQ_DEPTH = 24,
  parameter int WORD_W = 29,
  parameter int PC_W = 32,
  parameter int PRED_BITS = 6,
  localparam int LQ_W = $clog2(LQ_DEPTH),
  localparam int SQ_W = $clog2(SQ_DEPTH),
  localparam int IDX_W = (LQ_W > SQ_W) ? LQ_W : SQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_store,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              st_res_valid,
  input  logic [SQ_W-1:0]   st_res_idx,
  input  logic [WORD_W-1:0] st_res_word,
  input  logic [7:0]        st_res_mask,
  input  logic              ld_iss_valid,
  input  logic [LQ_W-1:0]   ld_iss_idx,
  input  logic [WORD_W-1:0] ld_iss_word,
  input  logic [7:0]        ld_iss_mask,
  output logic              ld_iss_ok,
  output logic              squash_valid,
  output logic [LQ_W-1:0]   squash_idx,
  input  logic [LQ_W-1:0]   qry_idx,
  output logic              qry_safe,
  input  logic              retire_ld,
  input  logic              retire_st
);
  import lsq_pkg::*;

  // ring pointers
  logic [LQ_W-1:0] lq_head, lq_tail;
  logic [SQ_W-1:0] sq_head, sq_tail;
  logic lq_full, lq_empty, sq_full, sq_empty;
  logic lq_push, lq_pop, sq_push, sq_pop;

  // load entries
  logic [LQ_DEPTH-1:0] lq_v_q, lq_v_d, lq_ex_q, lq_ex_d;
  logic [PC_W-1:0]     lq_pc_q [LQ_DEPTH];
  logic [PC_W-1:0]     lq_pc_d [LQ_DEPTH];
  seq_t                lq_mark_q [LQ_DEPTH];
  seq_t                lq_mark_d [LQ_DEPTH];
  logic [WORD_W-1:0]   lq_word_q [LQ_DEPTH];
  logic [WORD_W-1:0]   lq_word_d [LQ_DEPTH];
  bmask_t              lq_mask_q [LQ_DEPTH];
  bmask_t              lq_mask_d [LQ_DEPTH];

  // store entries
  logic [SQ_DEPTH-1:0] sq_v_q, sq_v_d, sq_kn_q, sq_kn_d;
  seq_t                sq_seq_q [SQ_DEPTH];
  seq_t                sq_seq_d [SQ_DEPTH];
  logic [WORD_W-1:0]   sq_word_q [SQ_DEPTH];
  logic [WORD_W-1:0]   sq_word_d [SQ_DEPTH];
  bmask_t              sq_mask_q [SQ_DEPTH];
  bmask_t              sq_mask_d [SQ_DEPTH];

  seq_t st_ctr_q, st_ctr_d;

  logic            pred_wait, older_unknown, iss_go;
  logic            hit_found;
  logic [LQ_W-1:0] hit_idx;
  int              hit_dist;
  logic            sq_valid_q;
  logic [LQ_W-1:0] sq_idx_q;

  assign lq_push = alloc_valid && !alloc_store && !lq_full;
  assign sq_push = alloc_valid &&  alloc_store && !sq_full;
  assign lq_pop  = retire_ld && !lq_empty;
  assign sq_pop  = retire_st && !sq_empty;

  lsq_ring_ctl #(.DEPTH(LQ_DEPTH)) u_lq_ring (
    .clk(clk), .rst_n(rst_n), .push(lq_push), .pop(lq_pop),
    .head(lq_head), .tail(lq_tail), .full(lq_full), .empty(lq_empty));

  lsq_ring_ctl #(.DEPTH(SQ_DEPTH)) u_sq_ring (
    .clk(clk), .rst_n(rst_n), .push(sq_push), .pop(sq_pop),
    .head(sq_head), .tail(sq_tail), .full(sq_full), .empty(sq_empty));

  lsq_wait_pred #(.PC_W(PC_W), .IDX_W(PRED_BITS)) u_pred (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(lq_pc_q[ld_iss_idx]), .rd_wait(pred_wait),
    .set_en(hit_found), .set_pc(lq_pc_q[hit_idx]));

  assign alloc_ready = alloc_store ? !sq_full : !lq_full;
  assign alloc_idx   = alloc_store ? IDX_W'(sq_tail) : IDX_W'(lq_tail);

  function automatic int lq_dist(int i, int h);
    return (i >= h) ? (i - h) : (i + LQ_DEPTH - h);
  endfunction

  // issue gating: wait-table hit plus an unresolved older store holds the load
  always_comb begin
    older_unknown = 1'b0;
    for (int s = 0; s < SQ_DEPTH; s++) begin
      if (sq_v_q[s] && !sq_kn_q[s] && seq_before(sq_seq_q[s], lq_mark_q[ld_iss_idx]))
        older_unknown = 1'b1;
    end
  end
  assign ld_iss_ok = !(pred_wait && older_unknown);
  assign iss_go    = ld_iss_valid && ld_iss_ok;

  // late overlap scan, oldest load first; includes a load issuing this cycle
  always_comb begin
    seq_t              res_seq;
    logic              ex_e;
    logic [WORD_W-1:0] w_e;
    bmask_t            m_e;
    int                i;
    hit_found = 1'b0;
    hit_idx   = '0;
    hit_dist  = 0;
    res_seq   = sq_seq_q[st_res_idx];
    for (int d = 0; d < LQ_DEPTH; d++) begin
      i = int'(lq_head) + d;
      if (i >= LQ_DEPTH) i = i - LQ_DEPTH;
      if (iss_go && (int'(ld_iss_idx) == i)) begin
        ex_e = 1'b1;
        w_e  = ld_iss_word;
        m_e  = ld_iss_mask;
      end else begin
        ex_e = lq_ex_q[i];
        w_e  = lq_word_q[i];
        m_e  = lq_mask_q[i];
      end
      if (st_res_valid && !hit_found && lq_v_q[i] && ex_e && (w_e == st_res_word) &&
          masks_touch(m_e, st_res_mask) && seq_before(res_seq, lq_mark_q[i])) begin
        hit_found = 1'b1;
        hit_idx   = LQ_W'(i);
        hit_dist  = d;
      end
    end
  end

  // load next state
  always_comb begin
    lq_v_d  = lq_v_q;
    lq_ex_d = lq_ex_q;
    for (int i = 0; i < LQ_DEPTH; i++) begin
      lq_pc_d[i]   = lq_pc_q[i];
      lq_mark_d[i] = lq_mark_q[i];
      lq_word_d[i] = lq_word_q[i];
      lq_mask_d[i] = lq_mask_q[i];
      if (lq_push && (int'(lq_tail) == i)) begin
        lq_v_d[i]    = 1'b1;
        lq_ex_d[i]   = 1'b0;
        lq_pc_d[i]   = alloc_pc;
        lq_mark_d[i] = st_ctr_q;
      end
      if (iss_go && (int'(ld_iss_idx) == i)) begin
        lq_ex_d[i]   = 1'b1;
        lq_word_d[i] = ld_iss_word;
        lq_mask_d[i] = ld_iss_mask;
      end
      if (hit_found && (lq_dist(i, int'(lq_head)) >= hit_dist)) lq_ex_d[i] = 1'b0;
      if (lq_pop && (int'(lq_head) == i)) lq_v_d[i] = 1'b0;
    end
  end

  // store next state
  always_comb begin
    sq_v_d   = sq_v_q;
    sq_kn_d  = sq_kn_q;
    st_ctr_d = sq_push ? st_ctr_q + 1'b1 : st_ctr_q;
    for (int s = 0; s < SQ_DEPTH; s++) begin
      sq_seq_d[s]  = sq_seq_q[s];
      sq_word_d[s] = sq_word_q[s];
      sq_mask_d[s] = sq_mask_q[s];
      if (sq_push && (int'(sq_tail) == s)) begin
        sq_v_d[s]   = 1'b1;
        sq_kn_d[s]  = 1'b0;
        sq_seq_d[s] = st_ctr_q;
      end
      if (st_res_valid && (int'(st_res_idx) == s)) begin
        sq_kn_d[s]   = 1'b1;
        sq_word_d[s] = st_res_word;
        sq_mask_d[s] = st_res_mask;
      end
      if (sq_pop && (int'(sq_head) == s)) sq_v_d[s] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lq_v_q     <= '0;
      lq_ex_q    <= '0;
      sq_v_q     <= '0;
      sq_kn_q    <= '0;
      st_ctr_q   <= '0;
      sq_valid_q <= 1'b0;
      sq_idx_q   <= '0;
      for (int i = 0; i < LQ_DEPTH; i++) begin
        lq_pc_q[i]   <= '0;
        lq_mark_q[i] <= '0;
        lq_word_q[i] <= '0;
        lq_mask_q[i] <= '0;
      end
      for (int s = 0; s < SQ_DEPTH; s++) begin
        sq_seq_q[s]  <= '0;
        sq_word_q[s] <= '0;
        sq_mask_q[s] <= '0;
      end
    end else begin
      lq_v_q     <= lq_v_d;
      lq_ex_q    <= lq_ex_d;
      sq_v_q     <= sq_v_d;
      sq_kn_q    <= sq_kn_d;
      st_ctr_q   <= st_ctr_d;
      sq_valid_q <= hit_found;
      sq_idx_q   <= hit_idx;
      for (int i = 0; i < LQ_DEPTH; i++) begin
        lq_pc_q[i]   <= lq_pc_d[i];
        lq_mark_q[i] <= lq_mark_d[i];
        lq_word_q[i] <= lq_word_d[i];
        lq_mask_q[i] <= lq_mask_d[i];
      end
      for (int s = 0; s < SQ_DEPTH; s++) begin
        sq_seq_q[s]  <= sq_seq_d[s];
        sq_word_q[s] <= sq_word_d[s];
        sq_mask_q[s] <= sq_mask_d[s];
      end
    end
  end

  assign squash_valid = sq_valid_q;
  assign squash_idx   = sq_idx_q;

  // safety query
  always_comb begin
    qry_safe = lq_v_q[qry_idx] && lq_ex_q[qry_idx];
    for (int s = 0; s < SQ_DEPTH; s++) begin
      if (sq_v_q[s] && seq_before(sq_seq_q[s], lq_mark_q[qry_idx]) &&
          (!sq_kn_q[s] || ((sq_word_q[s] == lq_word_q[qry_idx]) &&
                           masks_touch(sq_mask_q[s], lq_mask_q[qry_idx]))))
        qry_safe = 1'b0;
    end
  end

  AST_SQUASH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> $past(st_res_valid)); // R5
  AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> !lq_ex_q[squash_idx]); // R11
  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_store && alloc_ready) |-> !lq_v_q[lq_tail]); // R2
  AST_RESOLVE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    st_res_valid |-> sq_v_q[st_res_idx]); // R5
endmodule

// File: tb/lsq_disamb_top_tb_top.sv
module lsq_disamb_top_tb_top;
  localparam int LQ = 40;
  localparam int SQ = 24;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic alloc_valid, alloc_store, alloc_ready;
  logic [31:0] alloc_pc;
  logic [5:0] alloc_idx;
  logic st_res_valid;
  logic [4:0] st_res_idx;
  logic [28:0] st_res_word, ld_iss_word;
  logic [7:0] st_res_mask, ld_iss_mask;
  logic ld_iss_valid, ld_iss_ok, squash_valid, qry_safe, retire_ld, retire_st;
  logic [5:0] ld_iss_idx, squash_idx, qry_idx;

  lsq_disamb_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_pc(alloc_pc),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .st_res_valid(st_res_valid), .st_res_idx(st_res_idx), .st_res_word(st_res_word),
    .st_res_mask(st_res_mask),
    .ld_iss_valid(ld_iss_valid), .ld_iss_idx(ld_iss_idx), .ld_iss_word(ld_iss_word),
    .ld_iss_mask(ld_iss_mask), .ld_iss_ok(ld_iss_ok),
    .squash_valid(squash_valid), .squash_idx(squash_idx),
    .qry_idx(qry_idx), .qry_safe(qry_safe),
    .retire_ld(retire_ld), .retire_st(retire_st));

  int total = 0;
  int bad = 0;

  // bench mirror of the requirements
  bit lv [LQ]; bit lex [LQ]; int lpc [LQ]; int lmark [LQ]; int lw [LQ]; int lm [LQ];
  bit sv [SQ]; bit skn [SQ]; int sseq [SQ]; int sw [SQ]; int sm [SQ];
  bit pred [64];
  int lhead = 0, ltail = 0, lcnt = 0, shead = 0, stail = 0, scnt = 0, seqc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int hsh(int pc);
    logic [5:0] h;
    logic [31:0] p;
    p = pc;
    h = '0;
    for (int b = 0; b < 32; b++) h[b % 6] = h[b % 6] ^ p[b];
    return int'(h);
  endfunction

  function automatic bit ovl(int wa, int ma, int wb, int mb);
    return (wa == wb) && ((ma & mb) != 0);
  endfunction

  function automatic bit exp_ok(int li);
    bit unk;
    unk = 0;
    for (int s = 0; s < SQ; s++) if (sv[s] && !skn[s] && sseq[s] < lmark[li]) unk = 1;
    return !(pred[hsh(lpc[li])] && unk);
  endfunction

  function automatic bit exp_safe(int li);
    bit r;
    r = lv[li] && lex[li];
    for (int s = 0; s < SQ; s++)
      if (sv[s] && sseq[s] < lmark[li] && (!skn[s] || ovl(sw[s], sm[s], lw[li], lm[li]))) r = 0;
    return r;
  endfunction

  task automatic idle_inputs();
    alloc_valid = 0; alloc_store = 0; alloc_pc = 0;
    st_res_valid = 0; st_res_idx = 0; st_res_word = 0; st_res_mask = 0;
    ld_iss_valid = 0; ld_iss_idx = 0; ld_iss_word = 0; ld_iss_mask = 0;
    qry_idx = 0; retire_ld = 0; retire_st = 0;
  endtask

  task automatic do_alloc(input bit st, input int pc);
    bit er;
    @(negedge clk);
    alloc_valid = 1; alloc_store = st; alloc_pc = pc;
    #1;
    er = st ? (scnt < SQ) : (lcnt < LQ);
    chk(alloc_ready == er, "R2 ready", int'(alloc_ready), int'(er));
    if (er) chk(int'(alloc_idx) == (st ? stail : ltail), "R2 idx", int'(alloc_idx), st ? stail : ltail);
    @(posedge clk); #1;
    if (er && st) begin
      sv[stail] = 1; skn[stail] = 0; sseq[stail] = seqc; seqc++;
      stail = (stail + 1) % SQ; scnt++;
    end else if (er) begin
      lv[ltail] = 1; lex[ltail] = 0; lpc[ltail] = pc; lmark[ltail] = seqc;
      ltail = (ltail + 1) % LQ; lcnt++;
    end
    chk(squash_valid == 0, "R6 no squash on alloc", int'(squash_valid), 0);
    idle_inputs();
  endtask

  // optional issue (li>=0) and optional resolve (si>=0) in one cycle
  task automatic do_op(input int li, input int w, input int m, input int si, input int rw, input int rm,
                       input string req);
    bit ok;
    int hit, hd;
    @(negedge clk);
    if (li >= 0) begin
      ld_iss_valid = 1; ld_iss_idx = 6'(li); ld_iss_word = 29'(w); ld_iss_mask = 8'(m);
    end
    if (si >= 0) begin
      st_res_valid = 1; st_res_idx = 5'(si); st_res_word = 29'(rw); st_res_mask = 8'(rm);
    end
    #1;
    ok = 0;
    if (li >= 0) begin
      ok = exp_ok(li);
      chk(ld_iss_ok == ok, "R4/R8 issue gate", int'(ld_iss_ok), int'(ok));
    end
    @(posedge clk); #1;
    if (li >= 0 && ok) begin lex[li] = 1; lw[li] = w; lm[li] = m; end
    hit = -1; hd = 0;
    if (si >= 0) begin
      skn[si] = 1; sw[si] = rw; sm[si] = rm;
      for (int d = 0; d < lcnt; d++) begin
        int i;
        i = (lhead + d) % LQ;
        if (hit < 0 && lex[i] && sseq[si] < lmark[i] && ovl(lw[i], lm[i], rw, rm)) begin
          hit = i; hd = d;
        end
      end
    end
    chk(squash_valid == (hit >= 0), req, int'(squash_valid), int'(hit >= 0));
    if (hit >= 0) begin
      chk(int'(squash_idx) == hit, {req, " idx"}, int'(squash_idx), hit);
      pred[hsh(lpc[hit])] = 1;
      for (int d = hd; d < lcnt; d++) lex[(lhead + d) % LQ] = 0;
    end
    idle_inputs();
  endtask

  task automatic do_query(input int li, input string req);
    bit e;
    @(negedge clk);
    qry_idx = 6'(li);
    #1;
    e = exp_safe(li);
    chk(qry_safe == e, req, int'(qry_safe), int'(e));
    idle_inputs();
  endtask

  task automatic do_retire(input bit ld, input bit st);
    @(negedge clk);
    retire_ld = ld; retire_st = st;
    @(posedge clk); #1;
    if (ld && lcnt > 0) begin lv[lhead] = 0; lex[lhead] = 0; lhead = (lhead + 1) % LQ; lcnt--; end
    if (st && scnt > 0) begin sv[shead] = 0; shead = (shead + 1) % SQ; scnt--; end
    idle_inputs();
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int l0;
    void'($urandom(32'd1234));
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(alloc_ready == 1, "R1 ready", int'(alloc_ready), 1);
    chk(alloc_idx == 0, "R1 idx", int'(alloc_idx), 0);
    chk(squash_valid == 0, "R1 squash", int'(squash_valid), 0);
    chk(qry_safe == 0, "R1 safe", int'(qry_safe), 0);

    // speculative issue past unknown store, then disjoint mask
    do_alloc(1, 32'h100); do_alloc(0, 32'h100);
    do_op(0, 5, 8'h0F, -1, 0, 0, "R4 spec issue");
    do_query(0, "R9 unsafe while store unknown");
    do_op(-1, 0, 0, 0, 5, 8'hF0, "R6 disjoint mask");
    do_query(0, "R9 safe");
    // true overlap with younger executed loads
    do_alloc(1, 0); do_alloc(0, 32'h200); do_op(1, 7, 8'h01, -1, 0, 0, "R4 issue");
    do_alloc(0, 32'h300); do_op(2, 9, 8'hFF, -1, 0, 0, "R4 issue");
    do_op(-1, 0, 0, 1, 7, 8'h03, "R5 overlap squash");
    do_query(2, "R11 younger cleared");
    do_query(1, "R11 offender cleared");
    // wait predictor
    do_alloc(1, 0); do_alloc(0, 32'h200);
    do_op(3, 40, 8'h01, -1, 0, 0, "R8 held");
    do_op(-1, 0, 0, 2, 100, 8'hFF, "R6 other word");
    do_op(3, 40, 8'h01, -1, 0, 0, "R8 released");
    // older load not squashed
    do_alloc(0, 32'h400); do_op(4, 20, 8'h01, -1, 0, 0, "R4 issue");
    do_alloc(1, 0); do_op(-1, 0, 0, 3, 20, 8'h01, "R7 older load kept");
    // same-cycle issue and resolve
    do_alloc(1, 0); do_alloc(0, 32'h500);
    do_op(5, 30, 8'h04, 4, 30, 8'h04, "R10 same cycle");
    // drain, fill, empty-retire
    repeat (8) do_retire(1, 1);
    do_retire(1, 1);
    for (int k = 0; k < LQ + 1; k++) do_alloc(0, 32'h600 + 4 * k);
    for (int k = 0; k < SQ + 1; k++) do_alloc(1, 0);
    repeat (LQ + 2) do_retire(1, 1);
    do_alloc(0, 32'h700);
    chk(lcnt == 1, "R3 empty retire ignored", lcnt, 1);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 9);
      if (r <= 1) do_alloc(0, 32'h1000 + 4 * int'($urandom % 32));
      else if (r == 2) do_alloc(1, 0);
      else if (r <= 4 && lcnt > 0) begin
        l0 = (lhead + int'($urandom % lcnt)) % LQ;
        if (!lex[l0]) do_op(l0, int'($urandom % 4), 1 << ($urandom % 8) | 1 << ($urandom % 8), -1, 0, 0, "R4/R8 random issue");
        else do_query(l0, "R9 random query");
      end else if (r == 5 && scnt > 0) begin
        int s0;
        s0 = (shead + int'($urandom % scnt)) % SQ;
        if (!skn[s0]) do_op(-1, 0, 0, s0, int'($urandom % 4), 1 << ($urandom % 8), "R5/R7 random resolve");
      end else if (r == 6) do_retire(1, 0);
      else if (r == 7) do_retire(0, 1);
      else if (lcnt > 0) do_query((lhead + int'($urandom % lcnt)) % LQ, "R9/R11 random query");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule